// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store that sits beside a direct-mapped primary cache and keeps the lines that the primary has recently thrown out. Whenever the primary replaces a line, it offers that line (full line address, payload and dirty flag) to the buffer. Whenever the primary misses, it presents the missing line address on the probe port. A hit returns the line in the same cycle, so the primary can refill from the buffer instead of from memory. This absorbs conflict misses between blocks that compete for one direct-mapped entry.

A probe hit normally removes the returned entry. If the primary evicts a line in the same cycle, the evicted line takes over the freed entry in one operation, which is a swap. Entries are kept in arrival order. When every entry is occupied, a new line displaces the oldest one. A displaced dirty line is presented on a write-back port and held there until the memory side accepts it. A displaced clean line is simply dropped.

Top module: `victim_cache`

## Requirements
- R1: After reset, no entry is valid. Every probe misses, `wb_valid` is 0 and `ins_ready` is 1.
- R2: When `probe_valid` is high and `probe_addr` equals the full line address of a valid entry, `probe_hit` is 1 in the same cycle. In that cycle `probe_data` and `probe_dirty` show the stored payload and dirty flag of that entry.
- R3: A probe hit in a cycle with no accepted insertion removes the hit entry at the next clock edge. A later probe of that address misses.
- R4: A probe hit in a cycle with an accepted insertion of an address not already held is a swap. The inserted line takes the hit entry's place, the probed line is no longer held, the number of valid entries is unchanged and nothing is displaced.
- R5: An accepted insertion of an address that is not held, with no probe hit and fewer than 16 valid entries, adds a new entry. It displaces nothing.
- R6: Every write of a line makes that line the newest. An accepted insertion that needs a new entry while all 16 entries are valid displaces the oldest entry.
- R7: A displaced entry whose dirty flag is 1 appears on `wb_valid`/`wb_addr`/`wb_data` from the cycle after the insertion. It stays there unchanged until a cycle with `wb_ready` high. A displaced clean entry produces no write-back.
- R8: While `wb_valid` is 1 and `wb_ready` is 0, `ins_ready` is 0 and an offered insertion is ignored. The contents do not change through it.
- R9: An accepted insertion of an address already held updates that entry in place. The payload is replaced, the dirty flag becomes the OR of the old and new flags, and the entry becomes the newest. A probe hit on a different entry in that cycle does not remove that entry. No address is ever held twice, including when a probe and an insertion of the same address occur in one cycle.
- R10: At most one entry matches a probe. Across long mixed traffic of probes, insertions, swaps, displacements and write-back stalls, every output matches an arrival-order model of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Primary offers an evicted line |
| ins_ready | output | 1 | Insertion can be accepted this cycle |
| ins_addr | input | ADDR_W | Line address of the evicted line |
| ins_data | input | DATA_W | Payload of the evicted line |
| ins_dirty | input | 1 | Evicted line is modified |
| probe_valid | input | 1 | Primary miss lookup |
| probe_addr | input | ADDR_W | Line address looked up |
| probe_hit | output | 1 | Lookup found the line |
| probe_data | output | DATA_W | Payload of the hit line (0 on a miss) |
| probe_dirty | output | 1 | Dirty flag of the hit line (0 on a miss) |
| wb_valid | output | 1 | A displaced dirty line awaits write-back |
| wb_ready | input | 1 | Memory side accepts the write-back |
| wb_addr | output | ADDR_W | Line address being written back |
| wb_data | output | DATA_W | Payload being written back |

## Verification
The bench aims at the full buffer. If the age order is wrong after removals or swaps, a different line gets displaced, and the write-back or a later probe shows the wrong address. It also probes and inserts one address in the same cycle, and re-inserts a held address. A design that allocated blindly here would end up holding duplicate entries or lose the dirty flag. It stalls the write-back port while insertions keep coming. A design that overwrote the pending line or accepted an insertion during the stall would drop dirty data. Finally, probe hits that coincide with insertions check that the swap neither displaces a line nor frees an extra entry.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Where an accepted insertion lands
  typedef enum logic [2:0] {
    DST_NONE   = 3'd0,
    DST_MATCH  = 3'd1,  // address already held: update in place
    DST_SWAP   = 3'd2,  // take over the entry that the probe hit
    DST_FREE   = 3'd3,  // unused entry available
    DST_OLDEST = 3'd4   // buffer full: displace oldest
  } dst_kind_e;

endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 16,
  parameter int AW = 26
) (
  input  logic [N-1:0]          valid_i,
  input  logic [AW-1:0]         tags_i [N],
  input  logic [AW-1:0]         key_i,
  output logic [N-1:0]          vec_o,
  output logic                  any_o,
  output logic [$clog2(N)-1:0]  idx_o
);

  localparam int IW = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  assign any_o = |vec_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_o[i]) idx_o = idx_o | IW'(i);
    end
  end

endmodule

// File: rtl/vc_age.sv
module vc_age #(
  parameter int N = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          valid_i,
  input  logic                  wr_en_i,
  input  logic [$clog2(N)-1:0]  wr_idx_i,
  input  logic                  rm_en_i,
  input  logic [$clog2(N)-1:0]  rm_idx_i,
  output logic [$clog2(N)-1:0]  oldest_o,
  output logic                  oldest_found_o
);

  localparam int RW = $clog2(N);
  localparam logic [RW-1:0] RMAX = RW'(N - 1);

  // rank 0 = newest, rank count-1 = oldest, for valid entries only
  logic [RW-1:0] rank_q [N];
  logic [RW-1:0] rank_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank_d[i] = rank_q[i];
      if (wr_en_i) begin
        if (wr_idx_i == RW'(i)) begin
          rank_d[i] = '0;
        end else if (valid_i[i] &&
                     (!valid_i[wr_idx_i] || rank_q[i] < rank_q[wr_idx_i])) begin
          rank_d[i] = rank_q[i] + 1'b1;
        end
      end else if (rm_en_i) begin
        if (valid_i[i] && rm_idx_i != RW'(i) && rank_q[i] > rank_q[rm_idx_i]) begin
          rank_d[i] = rank_q[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= '0;
    end else if (wr_en_i || rm_en_i) begin
      for (int i = 0; i < N; i++) rank_q[i] <= rank_d[i];
    end
  end

  always_comb begin
    oldest_o       = '0;
    oldest_found_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && rank_q[i] == RMAX) begin
        oldest_o       = RW'(i);
        oldest_found_o = 1'b1;
      end
    end
  end

  // Checks on the age order
  logic rank_clash;
  always_comb begin
    rank_clash = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (valid_i[i] && valid_i[j] && rank_q[i] == rank_q[j]) rank_clash = 1'b1;
      end
    end
  end

  a_r6_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
    !rank_clash);

  a_r6_full_has_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_i) |-> oldest_found_o);

endmodule

// File: rtl/vc_wb.sv
module vc_wb #(
  parameter int AW = 26,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  output logic          busy_o,
  output logic          wb_valid_o,
  input  logic          wb_ready_i,
  output logic [AW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o
);

  logic wb_valid_d;

  assign busy_o = wb_valid_o && !wb_ready_i;

  always_comb begin
    wb_valid_d = wb_valid_o;
    if (wb_valid_o && wb_ready_i) wb_valid_d = 1'b0;
    if (load_i)                   wb_valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_valid_o <= 1'b0;
    else        wb_valid_o <= wb_valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      wb_addr_o <= load_addr_i;
      wb_data_o <= load_data_i;
    end
  end

  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));

  a_r8_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !(wb_valid_o && !wb_ready_i));

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data,
  output logic              probe_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  localparam int N  = ENTRIES;
  localparam int IW = $clog2(N);

  // Entry storage
  logic [N-1:0]      valid_q, valid_d;
  logic [N-1:0]      dirty_q, dirty_d;
  logic [ADDR_W-1:0] tag_q  [N];
  logic [DATA_W-1:0] data_q [N];

  // Lookup results
  logic [N-1:0]  p_vec, i_vec;
  logic          p_any, i_any;
  logic [IW-1:0] p_idx, i_idx;

  vc_match #(.N(N), .AW(ADDR_W)) u_probe_match (
    .valid_i (valid_q),
    .tags_i  (tag_q),
    .key_i   (probe_addr),
    .vec_o   (p_vec),
    .any_o   (p_any),
    .idx_o   (p_idx)
  );

  vc_match #(.N(N), .AW(ADDR_W)) u_ins_match (
    .valid_i (valid_q),
    .tags_i  (tag_q),
    .key_i   (ins_addr),
    .vec_o   (i_vec),
    .any_o   (i_any),
    .idx_o   (i_idx)
  );

  // Hit side
  logic p_hit_v;
  assign p_hit_v     = probe_valid && p_any;
  assign probe_hit   = p_hit_v;
  assign probe_data  = p_hit_v ? data_q[p_idx]  : '0;
  assign probe_dirty = p_hit_v ? dirty_q[p_idx] : 1'b0;

  // Insertion handshake
  logic wb_busy, ins_fire;
  assign ins_ready = !wb_busy;
  assign ins_fire  = ins_valid && ins_ready;

  // Free entry search (lowest unused)
  logic [IW-1:0] free_idx;
  logic          full;
  assign full = &valid_q;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IW'(i);
    end
  end

  // Destination choice
  logic [IW-1:0] oldest_idx;
  logic          oldest_found;
  dst_kind_e     kind;
  logic [IW-1:0] wr_idx;
  logic          wr_en, rm_en;

  always_comb begin
    kind   = DST_NONE;
    wr_idx = '0;
    if (ins_fire) begin
      if (i_any) begin
        kind   = DST_MATCH;
        wr_idx = i_idx;
      end else if (p_hit_v) begin
        kind   = DST_SWAP;
        wr_idx = p_idx;
      end else if (!full) begin
        kind   = DST_FREE;
        wr_idx = free_idx;
      end else begin
        kind   = DST_OLDEST;
        wr_idx = oldest_idx;
      end
    end
  end

  assign wr_en = (kind != DST_NONE);
  assign rm_en = p_hit_v && !ins_fire;

  vc_age #(.N(N)) u_age (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_i        (valid_q),
    .wr_en_i        (wr_en),
    .wr_idx_i       (wr_idx),
    .rm_en_i        (rm_en),
    .rm_idx_i       (p_idx),
    .oldest_o       (oldest_idx),
    .oldest_found_o (oldest_found)
  );

  // Displacement to write-back
  logic wb_load;
  assign wb_load = (kind == DST_OLDEST) && dirty_q[oldest_idx];

  vc_wb #(.AW(ADDR_W), .DW(DATA_W)) u_wb (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (wb_load),
    .load_addr_i (tag_q[oldest_idx]),
    .load_data_i (data_q[oldest_idx]),
    .busy_o      (wb_busy),
    .wb_valid_o  (wb_valid),
    .wb_ready_i  (wb_ready),
    .wb_addr_o   (wb_addr),
    .wb_data_o   (wb_data)
  );

  // Next state of the flags
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      dirty_d[wr_idx] = ins_dirty || ((kind == DST_MATCH) && dirty_q[wr_idx]);
    end
    if (rm_en) valid_d[p_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en || rm_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= ins_addr;
      data_q[wr_idx] <= ins_data;
    end
  end

  // Checks
  logic dup_found;
  always_comb begin
    dup_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup_found = 1'b1;
      end
    end
  end

  a_r9_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_found);

  a_r10_probe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_vec));

  a_r3_hit_removed: assert property (@(posedge clk) disable iff (!rst_n)
    (p_hit_v && !ins_fire) |=>
      !(probe_valid && probe_addr == $past(probe_addr) && probe_hit));

  a_r4_swap_same_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && p_hit_v && !i_any) |=>
      ($countones(valid_q) == $countones($past(valid_q))));

  a_r6_full_uses_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && full && !i_any && !p_hit_v) |-> oldest_found);

endmodule

// File: tb/tb_victim_cache.sv
module tb_victim_cache;

  localparam int AW = 26;
  localparam int DW = 32;
  localparam int NE = 16;
  localparam time TCK = 8ns;

  logic          clk, rst_n;
  logic          ins_valid, ins_ready, ins_dirty;
  logic [AW-1:0] ins_addr;
  logic [DW-1:0] ins_data;
  logic          probe_valid, probe_hit, probe_dirty;
  logic [AW-1:0] probe_addr;
  logic [DW-1:0] probe_data;
  logic          wb_valid, wb_ready;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  victim_cache #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE)) dut (
    .clk, .rst_n,
    .ins_valid, .ins_ready, .ins_addr, .ins_data, .ins_dirty,
    .probe_valid, .probe_addr, .probe_hit, .probe_data, .probe_dirty,
    .wb_valid, .wb_ready, .wb_addr, .wb_data
  );

  initial clk = 1'b0;
  always #(TCK / 2) clk = ~clk;

  // Reference model: queue in arrival order, index 0 = oldest
  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          dirty;
  } ent_t;

  ent_t          mq[$];
  logic          m_wbv;
  logic [AW-1:0] m_wba;
  logic [DW-1:0] m_wbd;

  int n_cmp = 0;
  int n_bad = 0;

  function automatic int find(input logic [AW-1:0] a);
    for (int k = 0; k < mq.size(); k++) if (mq[k].addr == a) return k;
    return -1;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit iv, input logic [AW-1:0] ia, input logic [DW-1:0] id,
                      input bit idt, input bit pv, input logic [AW-1:0] pa,
                      input bit wr, input string req);
    int ph, mi;
    bit fire, e_ready;
    ent_t ne, old;
    @(negedge clk);
    ins_valid = iv; ins_addr = ia; ins_data = id; ins_dirty = idt;
    probe_valid = pv; probe_addr = pa; wb_ready = wr;
    #1;
    ph = pv ? find(pa) : -1;
    e_ready = !(m_wbv && !wr);
    chk(req, "probe_hit", probe_hit, (ph >= 0));
    if (ph >= 0) begin
      chk(req, "probe_data", probe_data, mq[ph].data);
      chk(req, "probe_dirty", probe_dirty, mq[ph].dirty);
    end
    chk(req, "ins_ready", ins_ready, e_ready);
    chk(req, "wb_valid", wb_valid, m_wbv);
    if (m_wbv) begin
      chk(req, "wb_addr", wb_addr, m_wba);
      chk(req, "wb_data", wb_data, m_wbd);
    end
    @(posedge clk);
    fire = iv && e_ready;
    if (m_wbv && wr) m_wbv = 1'b0;
    if (fire) begin
      ne.addr = ia; ne.data = id; ne.dirty = idt;
      mi = find(ia);
      if (mi >= 0) begin
        ne.dirty = idt | mq[mi].dirty;
        mq.delete(mi);
      end else if (ph >= 0) begin
        mq.delete(ph);
      end else if (mq.size() == NE) begin
        old = mq.pop_front();
        if (old.dirty) begin
          m_wbv = 1'b1; m_wba = old.addr; m_wbd = old.data;
        end
      end
      mq.push_back(ne);
    end else if (ph >= 0) begin
      mq.delete(ph);
    end
  endtask

  task automatic idle(input logic [AW-1:0] pa, input bit pv, input string req);
    step(1'b0, '0, '0, 1'b0, pv, pa, 1'b1, req);
  endtask

  task automatic put(input logic [AW-1:0] a, input bit d, input bit wr, input string req);
    step(1'b1, a, DW'(a) ^ 32'h5A5A_0000, d, 1'b0, '0, wr, req);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    m_wbv = 1'b0;
    ins_valid = 0; ins_addr = '0; ins_data = '0; ins_dirty = 0;
    probe_valid = 0; probe_addr = '0; wb_ready = 1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    idle(26'h100, 1'b1, "R1");
    idle(26'h0, 1'b1, "R1");

    // R5: fill all entries, alternating dirty flags
    for (int k = 0; k < NE; k++) put(26'h200 + 26'(k), k[0], 1'b1, "R5");
    for (int k = 0; k < 3; k++) idle(26'h200 + 26'(k), 1'b0, "R5");

    // R2 + R3: a hit returns the line and then removes it
    idle(26'h203, 1'b1, "R2");
    idle(26'h203, 1'b1, "R3");
    put(26'h203, 1'b1, 1'b1, "R5");

    // R6 + R7: full, displace oldest (0x200 clean, then 0x201 dirty) with write-back stalled
    put(26'h300, 1'b0, 1'b0, "R6");
    put(26'h301, 1'b0, 1'b0, "R7");
    // R8: stalled write-back blocks insertion
    put(26'h302, 1'b1, 1'b0, "R8");
    put(26'h302, 1'b1, 1'b0, "R8");
    idle(26'h302, 1'b1, "R8");
    idle(26'h201, 1'b1, "R7");
    put(26'h302, 1'b1, 1'b1, "R7");
    put(26'h303, 1'b0, 1'b1, "R6");
    idle(26'h0, 1'b0, "R7");

    // R4: swap while full (probe 0x205, insert 0x400)
    step(1'b1, 26'h400, 32'hCAFE_0400, 1'b1, 1'b1, 26'h205, 1'b1, "R4");
    idle(26'h205, 1'b1, "R4");
    idle(26'h400, 1'b0, "R4");
    put(26'h401, 1'b0, 1'b1, "R4");

    // R9: same address probed and inserted in one cycle
    step(1'b1, 26'h207, 32'h1111_2222, 1'b0, 1'b1, 26'h207, 1'b1, "R9");
    idle(26'h207, 1'b1, "R9");
    // R9: re-insert held address, probe another held one
    put(26'h300, 1'b0, 1'b1, "R9");
    step(1'b1, 26'h300, 32'h3333_4444, 1'b0, 1'b1, 26'h209, 1'b1, "R9");
    idle(26'h209, 1'b1, "R9");
    idle(26'h300, 1'b1, "R9");

    // R10: long mixed traffic
    for (int c = 0; c < 4000; c++) begin
      logic [AW-1:0] ra, rp;
      ra = 26'h500 + 26'($urandom_range(0, 23));
      rp = 26'h500 + 26'($urandom_range(0, 23));
      step($urandom_range(0, 9) < 6, ra, $urandom(), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, rp, $urandom_range(0, 3) != 0, "R10");
    end
    for (int k = 0; k < 4; k++) idle(26'h0, 1'b0, "R10");

    summary();
    $finish;
  end

endmodule